// File: doc/BRIEF.md
# Exception Control Register Unit

This unit keeps the privileged exception state of a small processor. It holds four index-selected registers: the saved program counter, the cause code, the faulting address and the enable mask. It also keeps a single flag that tells whether the core runs in privileged mode. The core presents its exception request lines every cycle, along with the current PC and the faulting address. When at least one enabled request is present, the unit asserts a redirect to a fixed handler address in that same cycle. At the next clock edge it captures the saved state and enters privileged mode.

Software reaches the registers through three decoded strobes with a 5-bit register index: a register read, a register write and a return-from-exception. Reads and writes are legal only in privileged mode. In user mode they raise an illegal-instruction exception of their own. The return strobe drops the processor back to user mode. A system call arrives as an ordinary request line.

Top module: `exc_ctl_unit`

## Requirements
- R1: Synchronous active-low reset clears every register to zero and sets privileged mode. Reads of indices 8, 12, 13 and 14 then return zero.
- R2: When at least one effective request is present, `redirect` is high in the same cycle and `redirect_pc` equals the handler address (default 0x80). `priv_mode` is 1 from the next cycle onward.
- R3: On a taken exception, the register at index 14 captures `cur_pc` and the register at index 8 captures `fault_addr`.
- R4: When several effective requests arrive together, the lowest-numbered line wins. Its number is written into the cause register at index 13, in bits [CAUSE_W-1:0] with the upper bits zero.
- R5: A request line whose mask bit is clear is ignored. It produces no redirect and changes no register.
- R6: The mask register sits at index 12. Only its low NCAUSE bits are stored, and bit k enables request line k. A read returns those bits zero-extended.
- R7: A register read or register write issued in user mode drives `illegal_op` high. It raises an exception with cause code 2 that the mask cannot disable, it writes nothing, and `rd_data` stays zero.
- R8: A read of any index other than 8, 12, 13 or 14 returns zero. A write to such an index has no effect.
- R9: A return strobe in privileged mode clears `priv_mode` at the next edge. If an exception is taken in the same cycle, the exception wins and `priv_mode` stays 1.
- R10: A register write that coincides with a taken exception is dropped. The exception capture is what remains in the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | NCAUSE | Exception request lines, bit k is cause code k |
| cur_pc | input | XLEN | PC of the instruction in flight |
| fault_addr | input | XLEN | Faulting virtual address |
| op_read | input | 1 | Decoded register-read strobe |
| op_write | input | 1 | Decoded register-write strobe |
| op_return | input | 1 | Decoded return-from-exception strobe |
| reg_idx | input | 5 | Register index for read/write |
| wr_data | input | XLEN | Write data |
| redirect | output | 1 | Take exception, fetch from `redirect_pc` |
| redirect_pc | output | XLEN | Handler address |
| rd_data | output | XLEN | Read data |
| priv_mode | output | 1 | 1 when in privileged mode |
| illegal_op | output | 1 | Privileged access attempted in user mode |

## Verification
On every cycle, the assertions check the following:
- Entry into privileged mode follows each redirect.
- The saved PC and the cause code match the values presented at the moment the exception was taken.
- A user-mode access always raises a redirect, and a user-mode read returns zero.
- The mode flag changes only through an exception or a return.

Only the bench scenarios can show the rest:
- Priority among simultaneous requests, as seen through read-back.
- The effect of the mask.
- That writes to unimplemented indices vanish.
- That a write coinciding with an exception is dropped.

These need a sequence of accesses and a model of the register contents.

// File: rtl/exc_pkg.sv
// Shared constants for the exception control unit.
// Assumes: register indices are fixed by software convention.
package exc_pkg;
    localparam logic [4:0] IDX_BADADDR = 5'd8;
    localparam logic [4:0] IDX_MASK    = 5'd12;
    localparam logic [4:0] IDX_CAUSE   = 5'd13;
    localparam logic [4:0] IDX_EPC     = 5'd14;
endpackage

// File: rtl/exc_access_guard.sv
// Qualifies the decoded access strobes by the current mode.
// Assumes: at most one of read/write/return is set in a cycle.
module exc_access_guard (
    input  logic op_read,
    input  logic op_write,
    input  logic op_return,
    input  logic priv,
    output logic rd_ok,
    output logic wr_ok,
    output logic ret_ok,
    output logic illegal
);
    // Privileged accesses pass only in privileged mode.
    always_comb begin
        rd_ok   = op_read & priv;
        wr_ok   = op_write & priv;
        ret_ok  = op_return & priv;
        illegal = (op_read | op_write) & ~priv;
    end
endmodule

// File: rtl/exc_arbiter.sv
// Masks request lines, adds the illegal-access cause, picks the lowest code.
// Assumes: ILL_CODE < NCAUSE; the illegal cause ignores the mask.
module exc_arbiter #(
    parameter int NCAUSE   = 8,
    parameter int ILL_CODE = 2,
    localparam int CAUSE_W = $clog2(NCAUSE)
) (
    input  logic [NCAUSE-1:0]  req,
    input  logic [NCAUSE-1:0]  mask,
    input  logic               illegal,
    output logic               take,
    output logic [CAUSE_W-1:0] code
);
    logic [NCAUSE-1:0] eff;

    // Effective request vector and lowest-index winner.
    always_comb begin
        eff  = (req & mask) | (NCAUSE'(illegal) << ILL_CODE);
        take = |eff;
        code = '0;
        for (int i = NCAUSE - 1; i >= 0; i--) begin
            if (eff[i]) code = CAUSE_W'(i);
        end
    end
endmodule

// File: rtl/exc_state_regs.sv
// Holds saved PC, cause, bad address, mask and the mode flag; read mux.
// Assumes: XLEN > NCAUSE; take has priority over write and return.
module exc_state_regs
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NCAUSE = 8,
    localparam int CAUSE_W = $clog2(NCAUSE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [CAUSE_W-1:0] take_code,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    fault_addr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic               ret_en,
    input  logic [4:0]         idx,
    input  logic [XLEN-1:0]    wr_data,
    output logic [XLEN-1:0]    rd_data,
    output logic               priv_q,
    output logic [NCAUSE-1:0]  mask_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [XLEN-1:0]    epc_q
);
    logic [XLEN-1:0] bad_q;

    // State update: exception capture, else return and register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
            bad_q   <= '0;
            mask_q  <= '0;
            priv_q  <= 1'b1;
        end else if (take) begin
            epc_q   <= cur_pc;
            cause_q <= take_code;
            bad_q   <= fault_addr;
            priv_q  <= 1'b1;
        end else begin
            if (ret_en) priv_q <= 1'b0;
            if (wr_en) begin
                case (idx)
                    IDX_EPC:     epc_q   <= wr_data;
                    IDX_CAUSE:   cause_q <= wr_data[CAUSE_W-1:0];
                    IDX_BADADDR: bad_q   <= wr_data;
                    IDX_MASK:    mask_q  <= wr_data[NCAUSE-1:0];
                    default:     ;
                endcase
            end
        end
    end

    // Read mux, zero for unimplemented indices or when not enabled.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (idx)
                IDX_EPC:     rd_data = epc_q;
                IDX_CAUSE:   rd_data = {{(XLEN-CAUSE_W){1'b0}}, cause_q};
                IDX_BADADDR: rd_data = bad_q;
                IDX_MASK:    rd_data = {{(XLEN-NCAUSE){1'b0}}, mask_q};
                default:     rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/exc_ctl_unit.sv
// Top of the exception control unit: guard, arbiter and register state.
// Assumes: the core applies redirect in the same cycle it is raised.
module exc_ctl_unit #(
    parameter int          XLEN       = 32,
    parameter int          NCAUSE     = 8,
    parameter int          ILL_CODE   = 2,
    parameter logic [31:0] HANDLER_PC = 32'h0000_0080,
    localparam int         CAUSE_W    = $clog2(NCAUSE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] exc_req,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   fault_addr,
    input  logic              op_read,
    input  logic              op_write,
    input  logic              op_return,
    input  logic [4:0]        reg_idx,
    input  logic [XLEN-1:0]   wr_data,
    output logic              redirect,
    output logic [XLEN-1:0]   redirect_pc,
    output logic [XLEN-1:0]   rd_data,
    output logic              priv_mode,
    output logic              illegal_op
);
    logic               rd_ok, wr_ok, ret_ok, illegal, take;
    logic [CAUSE_W-1:0] win_code, cause_q;
    logic [NCAUSE-1:0]  mask_q;
    logic [XLEN-1:0]    epc_q;
    logic               priv_q;

    exc_access_guard u_guard (
        .op_read(op_read), .op_write(op_write), .op_return(op_return),
        .priv(priv_q), .rd_ok(rd_ok), .wr_ok(wr_ok), .ret_ok(ret_ok),
        .illegal(illegal)
    );

    exc_arbiter #(.NCAUSE(NCAUSE), .ILL_CODE(ILL_CODE)) u_arb (
        .req(exc_req), .mask(mask_q), .illegal(illegal),
        .take(take), .code(win_code)
    );

    exc_state_regs #(.XLEN(XLEN), .NCAUSE(NCAUSE)) u_regs (
        .clk(clk), .rst_n(rst_n), .take(take), .take_code(win_code),
        .cur_pc(cur_pc), .fault_addr(fault_addr),
        .wr_en(wr_ok & ~take), .rd_en(rd_ok), .ret_en(ret_ok & ~take),
        .idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data),
        .priv_q(priv_q), .mask_q(mask_q), .cause_q(cause_q), .epc_q(epc_q)
    );

    // Drive the block outputs.
    always_comb begin
        redirect    = take;
        redirect_pc = XLEN'(HANDLER_PC);
        priv_mode   = priv_q;
        illegal_op  = illegal;
    end
endmodule

// File: rtl/exc_ctl_unit_chk.sv
// Assertion checker for exc_ctl_unit, attached by bind.
// Assumes: inputs are stable around the rising clock edge.
module exc_ctl_unit_chk #(
    parameter int XLEN = 32,
    parameter int CAUSE_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               redirect,
    input logic               illegal_op,
    input logic               priv_mode,
    input logic               op_read,
    input logic               op_return,
    input logic [XLEN-1:0]    rd_data,
    input logic [XLEN-1:0]    cur_pc,
    input logic [XLEN-1:0]    epc_q,
    input logic [CAUSE_W-1:0] win_code,
    input logic [CAUSE_W-1:0] cause_q
);
    // R2
    take_enters_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> priv_mode);
    // R3
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> epc_q == $past(cur_pc));
    // R4
    cause_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> cause_q == $past(win_code));
    // R7
    illegal_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> redirect);
    // R7
    user_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv_mode && op_read) |-> rd_data == '0);
    // R9
    return_to_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_return && priv_mode && !redirect) |=> !priv_mode);
    // R9
    mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !op_return) |=> $stable(priv_mode));
endmodule

bind exc_ctl_unit exc_ctl_unit_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .redirect(redirect), .illegal_op(illegal_op),
    .priv_mode(priv_mode), .op_read(op_read), .op_return(op_return),
    .rd_data(rd_data), .cur_pc(cur_pc), .epc_q(epc_q),
    .win_code(win_code), .cause_q(cause_q)
);

// File: tb/tb_exc_ctl_unit.sv
module tb_exc_ctl_unit;
    localparam int          CLK_PERIOD = 10;
    localparam int          NC = 8;
    localparam int          ILL = 2;
    localparam logic [31:0] HANDLER = 32'h0000_0080;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NC-1:0] exc_req = '0;
    logic [31:0] cur_pc = '0, fault_addr = '0, wr_data = '0;
    logic op_read = 0, op_write = 0, op_return = 0;
    logic [4:0] reg_idx = '0;
    logic redirect, priv_mode, illegal_op;
    logic [31:0] redirect_pc, rd_data;

    int checks = 0, errors = 0;

    // Reference state
    logic [31:0] m_epc, m_bad;
    logic [2:0]  m_cause;
    logic [NC-1:0] m_mask;
    logic m_priv;

    exc_ctl_unit dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cur_pc(cur_pc),
        .fault_addr(fault_addr), .op_read(op_read), .op_write(op_write),
        .op_return(op_return), .reg_idx(reg_idx), .wr_data(wr_data),
        .redirect(redirect), .redirect_pc(redirect_pc), .rd_data(rd_data),
        .priv_mode(priv_mode), .illegal_op(illegal_op)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [4:0] ix);
        case (ix)
            5'd14:   return m_epc;
            5'd13:   return {29'd0, m_cause};
            5'd8:    return m_bad;
            5'd12:   return {24'd0, m_mask};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string read_tag(input logic [4:0] ix);
        case (ix)
            5'd14, 5'd8: return "R3";
            5'd13:       return "R4";
            5'd12:       return "R6";
            default:     return "R8";
        endcase
    endfunction

    // One cycle: drive, check combinational outputs, update the model.
    task automatic step(input logic [NC-1:0] rq, input logic rd, wr, rt,
                        input logic [4:0] ix, input logic [31:0] wd, pc, fa,
                        input string tag);
        logic ill, tk;
        logic [NC-1:0] eff;
        logic [2:0] code;
        logic [31:0] exp_rd;
        @(negedge clk);
        exc_req = rq; op_read = rd; op_write = wr; op_return = rt;
        reg_idx = ix; wr_data = wd; cur_pc = pc; fault_addr = fa;
        #2;
        ill  = (rd | wr) & ~m_priv;
        eff  = (rq & m_mask) | (ill ? NC'(1) << ILL : '0);
        tk   = |eff;
        code = 3'd0;
        for (int i = NC - 1; i >= 0; i--) if (eff[i]) code = 3'(i);
        exp_rd = (rd && m_priv) ? model_read(ix) : 32'd0;
        chk(tag != "" ? tag : "R2", "redirect", 32'(redirect), 32'(tk));
        if (tk) chk(tag != "" ? tag : "R2", "redirect_pc", redirect_pc, HANDLER);
        chk(tag != "" ? tag : "R7", "illegal_op", 32'(illegal_op), 32'(ill));
        chk(tag != "" ? tag : (m_priv ? read_tag(ix) : "R7"), "rd_data", rd_data, exp_rd);
        chk(tag != "" ? tag : "R9", "priv_mode", 32'(priv_mode), 32'(m_priv));
        @(posedge clk);
        if (tk) begin
            m_epc = pc; m_bad = fa; m_cause = code; m_priv = 1'b1;
        end else begin
            if (rt && m_priv) m_priv = 1'b0;
            if (wr && m_priv_before(rt)) begin
                case (ix)
                    5'd14: m_epc = wd;
                    5'd13: m_cause = wd[2:0];
                    5'd8:  m_bad = wd;
                    5'd12: m_mask = wd[NC-1:0];
                    default: ;
                endcase
            end
        end
    endtask

    // Write legality uses the mode at issue; a write never shares a cycle with a return.
    function automatic logic m_priv_before(input logic rt);
        return rt ? 1'b0 : m_priv;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_epc = 0; m_bad = 0; m_cause = 0; m_mask = 0; m_priv = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1 chk("R1", "priv after reset", 32'(priv_mode), 32'd1);
        // R1 reads after reset
        step('0, 1, 0, 0, 5'd8,  0, 0, 0, "R1");
        step('0, 1, 0, 0, 5'd12, 0, 0, 0, "R1");
        step('0, 1, 0, 0, 5'd13, 0, 0, 0, "R1");
        step('0, 1, 0, 0, 5'd14, 0, 0, 0, "R1");
        // R6 mask width
        step('0, 0, 1, 0, 5'd12, 32'hFFFF_FFFF, 0, 0, "R6");
        step('0, 1, 0, 0, 5'd12, 0, 0, 0, "R6");
        // R8 unimplemented index
        step('0, 0, 1, 0, 5'd5, 32'h1234_5678, 0, 0, "R8");
        step('0, 1, 0, 0, 5'd5, 0, 0, 0, "R8");
        // R4 priority, R3 capture
        step(8'b1010_1000, 0, 0, 0, 0, 0, 32'h100, 32'h200, "R4");
        step('0, 1, 0, 0, 5'd13, 0, 0, 0, "R4");
        step('0, 1, 0, 0, 5'd14, 0, 0, 0, "R3");
        step('0, 1, 0, 0, 5'd8,  0, 0, 0, "R3");
        // R9 return, R7 user access
        step('0, 0, 0, 1, 0, 0, 0, 0, "R9");
        step('0, 1, 0, 0, 5'd14, 0, 32'h300, 0, "R7");
        step('0, 1, 0, 0, 5'd13, 0, 0, 0, "R7");
        // R5 masked requests
        step('0, 0, 1, 0, 5'd12, 32'h08, 0, 0, "R6");
        step(8'hF0, 0, 0, 0, 0, 0, 32'h500, 32'h600, "R5");
        step('0, 1, 0, 0, 5'd14, 0, 0, 0, "R5");
        // R10 write dropped by coincident exception
        step(8'h08, 0, 1, 0, 5'd14, 32'hDEAD, 32'h444, 0, "R10");
        step('0, 1, 0, 0, 5'd14, 0, 0, 0, "R10");
        // R9 exception beats return
        step(8'h08, 0, 0, 1, 0, 0, 32'h48, 0, "R9");
        step('0, 0, 0, 0, 0, 0, 0, 0, "R9");
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [NC-1:0] rq;
            logic rd, wr, rt;
            logic [4:0] ix;
            int op, sel;
            rq = ($urandom % 6 == 0) ? NC'($urandom) : '0;
            op = $urandom % 20;
            rd = (op < 6); wr = (op >= 6 && op < 10); rt = (op == 10);
            sel = $urandom % 6;
            case (sel)
                0: ix = 5'd8;
                1: ix = 5'd12;
                2: ix = 5'd13;
                3: ix = 5'd14;
                default: ix = 5'($urandom);
            endcase
            step(rq, rd, wr, rt, ix, $urandom, $urandom, $urandom, "");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule